// File: doc/BRIEF.md
# Nap and Sleep Power Controller

This block sequences the low-power states of a sampling converter. A shutdown request input, active low, sends the converter into a low-power state. A separate depth-select input picks which state. The light state is nap. It turns off the analog bias but keeps the reference powered, so the converter wakes quickly. The deep state is sleep. It also turns off the reference, so the reference must settle again before the converter can be used, and waking takes far longer.

The block drives two enables, one for the analog bias and one for the reference. It also drives a ready flag that marks when conversions are allowed. After shutdown is released, a cycle counter times the wake-up, with one parameterised length for each depth. Conversion-start requests pass through to a registered start pulse only while ready is high. Requests that arrive while ready is low are dropped.

Top module: `pwr_nap_sleep_ctl`

## Requirements
- R1: After reset the block is active: `ready`, `biasEn` and `refEn` are 1 and `startGo` is 0.
- R2: If `shutdownN` is sampled 0 while the block is active, `ready` and `biasEn` are 0 from the next cycle on.
- R3: The depth is nap when `napSel` is 1 at shutdown entry. In nap, `refEn` stays 1 for the whole low-power period.
- R4: The depth is sleep when `napSel` is 0 at shutdown entry. In sleep, `refEn` is 0 from the cycle after entry until wake-up begins.
- R5: The depth is captured only in the cycle where shutdown is entered. Changes on `napSel` while `shutdownN` stays 0, or during the later wake-up, have no effect.
- R6: Wake-up from nap works as follows. Call the first clock edge that samples `shutdownN` at 1 edge 1. `ready` rises at edge NAP_CYCLES+1 and not before.
- R7: Wake-up from sleep uses the same count from that first high-sampling edge. `ready` rises at edge SLEEP_CYCLES+1 and not before.
- R8: During wake-up, `biasEn` and `refEn` are 1 and `ready` is 0.
- R9: A `startReq` sampled at a clock edge while `ready` is 1 produces `startGo` = 1 for the following cycle.
- R10: A `startReq` sampled while `ready` is 0 is discarded. It produces no `startGo`, either then or after ready returns.
- R11: If `shutdownN` is sampled 0 during wake-up, the countdown is cancelled and the block re-enters low power with the depth taken from `napSel` at that edge. This holds even in the cycle where the countdown would expire. A later release restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shutdownN | input | 1 | 0 requests low power, 1 requests operation |
| napSel | input | 1 | Depth select at shutdown entry: 1 nap, 0 sleep |
| startReq | input | 1 | Conversion-start request |
| biasEn | output | 1 | Analog bias enable |
| refEn | output | 1 | Reference enable |
| ready | output | 1 | Conversions allowed |
| startGo | output | 1 | Accepted conversion start, one cycle after the request |

## Verification
Two events can land on the same clock edge. One is wake-up expiry. The other is either a start request or a renewed shutdown request. The bench drives `startReq` high on every cycle of each wake-up window, so a request lands on the edge where `ready` rises. That request must be dropped, and the very next one must be accepted. The bench also drops `shutdownN` on the exact edge where the countdown reaches zero; the block must fall back to low power rather than become ready. A reference model in the bench predicts each of these outcomes from the requirements.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_DOWN   = 2'd1,
    PS_WAKE   = 2'd2
  } pwrState_t;

  // strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic captureMode;  // latch depth select on shutdown entry
    logic loadWake;     // preload wake-up counter for captured depth
    logic countDown;    // decrement wake-up counter
  } pwrStrobe_t;

endpackage

// File: rtl/pwr_wake_datapath.sv
module pwr_wake_datapath
  import pwr_ctl_pkg::*;
#(
  parameter int NAP_CYCLES   = 10,
  parameter int SLEEP_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwrStrobe_t strobe,
  input  logic       napSel,
  input  logic       startReq,
  input  logic       readyNow,
  output logic       modeNap,
  output logic       cntZero,
  output logic       startGo
);

  localparam int MAX_LEN = (NAP_CYCLES > SLEEP_CYCLES) ? NAP_CYCLES : SLEEP_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] NAP_LOAD   = CNT_W'(NAP_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLEEP_LOAD = CNT_W'(SLEEP_CYCLES - 1);

  logic [CNT_W-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeNap <= 1'b1;
    end else if (strobe.captureMode) begin
      modeNap <= napSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (strobe.loadWake) begin
      wakeCnt <= modeNap ? NAP_LOAD : SLEEP_LOAD;
    end else if (strobe.countDown) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign cntZero = (wakeCnt == '0);

  // start gate: accepted only while ready, never remembered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startGo <= 1'b0;
    end else begin
      startGo <= startReq & readyNow;
    end
  end

endmodule

// File: rtl/pwr_ctrl_fsm.sv
module pwr_ctrl_fsm
  import pwr_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       shutdownN,
  input  logic       cntZero,
  input  logic       modeNap,
  output pwrStrobe_t strobe,
  output logic       biasEn,
  output logic       refEn,
  output logic       ready
);

  pwrState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_ACTIVE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      PS_ACTIVE: begin
        if (!shutdownN) begin
          stateD             = PS_DOWN;
          strobe.captureMode = 1'b1;
        end
      end
      PS_DOWN: begin
        if (shutdownN) begin
          stateD          = PS_WAKE;
          strobe.loadWake = 1'b1;
        end
      end
      PS_WAKE: begin
        // renewed shutdown wins over expiry
        if (!shutdownN) begin
          stateD             = PS_DOWN;
          strobe.captureMode = 1'b1;
        end else if (cntZero) begin
          stateD = PS_ACTIVE;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: begin
        stateD = PS_ACTIVE;
      end
    endcase
  end

  assign ready  = (stateQ == PS_ACTIVE);
  assign biasEn = (stateQ != PS_DOWN);
  assign refEn  = (stateQ != PS_DOWN) || modeNap;

endmodule

// File: rtl/pwr_nap_sleep_ctl.sv
module pwr_nap_sleep_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int NAP_CYCLES   = 10,
  parameter int SLEEP_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic shutdownN,
  input  logic napSel,
  input  logic startReq,
  output logic biasEn,
  output logic refEn,
  output logic ready,
  output logic startGo
);

  pwrStrobe_t strobe;
  logic       modeNap;
  logic       cntZero;

  pwr_ctrl_fsm i_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .shutdownN (shutdownN),
    .cntZero   (cntZero),
    .modeNap   (modeNap),
    .strobe    (strobe),
    .biasEn    (biasEn),
    .refEn     (refEn),
    .ready     (ready)
  );

  pwr_wake_datapath #(
    .NAP_CYCLES   (NAP_CYCLES),
    .SLEEP_CYCLES (SLEEP_CYCLES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .napSel   (napSel),
    .startReq (startReq),
    .readyNow (ready),
    .modeNap  (modeNap),
    .cntZero  (cntZero),
    .startGo  (startGo)
  );

endmodule

// File: rtl/pwr_ctl_checker.sv
module pwr_ctl_checker (
  input logic clk,
  input logic rstN,
  input logic shutdownN,
  input logic napSel,
  input logic startReq,
  input logic biasEn,
  input logic refEn,
  input logic ready,
  input logic startGo
);

  AST_ENTRY_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !shutdownN) |=> (!ready && !biasEn)); // R2

  AST_NAP_KEEPS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !shutdownN && napSel) |=> refEn); // R3

  AST_NAP_HOLD_REF: assert property (@(posedge clk) disable iff (!rstN)
    (!biasEn && refEn && !shutdownN) |=> refEn); // R3

  AST_SLEEP_CUTS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !shutdownN && !napSel) |=> !refEn); // R4

  AST_WAKE_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    (biasEn && !ready) |-> refEn); // R8

  AST_START_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && ready) |=> startGo); // R9

  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !(startReq && ready) |=> !startGo); // R10

  AST_WAKE_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (biasEn && !ready && !shutdownN) |=> (!biasEn && !ready)); // R11

endmodule

bind pwr_nap_sleep_ctl pwr_ctl_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .shutdownN (shutdownN),
  .napSel    (napSel),
  .startReq  (startReq),
  .biasEn    (biasEn),
  .refEn     (refEn),
  .ready     (ready),
  .startGo   (startGo)
);

// File: tb/test_pwr_nap_sleep_ctl.sv
module test_pwr_nap_sleep_ctl;

  localparam int NAP = 5;
  localparam int SLP = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shutdownN = 1'b1;
  logic napSel = 1'b0;
  logic startReq = 1'b0;
  logic biasEn, refEn, ready, startGo;

  always #10 clk = ~clk;  // 50 MHz

  pwr_nap_sleep_ctl #(.NAP_CYCLES(NAP), .SLEEP_CYCLES(SLP)) i_pwr_nap_sleep_ctl (
    .clk(clk), .rstN(rstN), .shutdownN(shutdownN), .napSel(napSel),
    .startReq(startReq), .biasEn(biasEn), .refEn(refEn), .ready(ready),
    .startGo(startGo)
  );

  typedef struct {
    logic  rdy;
    logic  bias;
    logic  ref_;
    logic  go;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int nChecks = 0;
  int nFails  = 0;

  // requirement-level model: 0 active, 1 low power, 2 waking
  int   mSt  = 0;
  logic mNap = 1'b1;
  int   mCnt = 0;

  task automatic step(input logic sd, input logic sel, input logic req, input string tag);
    expItem_t e;
    logic wasReady;
    @(negedge clk);
    shutdownN = sd;
    napSel    = sel;
    startReq  = req;
    wasReady  = (mSt == 0);
    case (mSt)
      0: if (!sd) begin mSt = 1; mNap = sel; end
      1: if (sd) begin mSt = 2; mCnt = (mNap ? NAP : SLP) - 1; end
      default: begin
        if (!sd) begin mSt = 1; mNap = sel; end
        else if (mCnt == 0) mSt = 0;
        else mCnt = mCnt - 1;
      end
    endcase
    e.rdy  = (mSt == 0);
    e.bias = (mSt != 1);
    e.ref_ = (mSt != 1) || mNap;
    e.go   = req && wasReady;
    e.tag  = tag;
    scoreQ.push_back(e);
  endtask

  // monitor: compare after each edge, away from it
  initial begin
    forever begin
      expItem_t e;
      @(posedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        e = scoreQ.pop_front();
        nChecks++;
        if ({ready, biasEn, refEn, startGo} !== {e.rdy, e.bias, e.ref_, e.go}) begin
          nFails++;
          $display("FAIL %s: ready/bias/ref/go actual %b%b%b%b expected %b%b%b%b at %0t",
                   e.tag, ready, biasEn, refEn, startGo, e.rdy, e.bias, e.ref_, e.go, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #5;
    nChecks++;
    if ({ready, biasEn, refEn, startGo} !== 4'b1110) begin
      nFails++;
      $display("FAIL R1: reset state actual %b%b%b%b expected 1110", ready, biasEn, refEn, startGo);
    end

    // active, requests accepted
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R9");
    step(1, 0, 0, "R9");

    // nap entry, select wiggles, requests dropped
    step(0, 1, 1, "R2");
    for (int i = 0; i < 5; i++) step(0, i[0], 1, "R3/R5/R10");
    for (int i = 0; i < NAP + 3; i++) step(1, 0, 1, "R6/R8/R10");

    // sleep entry, select wiggles while low and during wake
    step(0, 0, 0, "R4");
    for (int i = 0; i < 6; i++) step(0, 1, 1, "R4/R5");
    for (int i = 0; i < SLP + 3; i++) step(1, 1, 1, "R7/R8/R5");

    // cancel a sleep wake-up midway, re-enter as nap
    step(0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) step(1, 0, 0, "R7/R8");
    step(0, 1, 1, "R11");
    step(0, 1, 0, "R11");
    for (int i = 0; i < NAP + 3; i++) step(1, 0, 1, "R11/R6");

    // shutdown on the very expiry edge
    step(0, 1, 0, "R2");
    step(1, 1, 0, "R6");
    while (!(mSt == 2 && mCnt == 0)) step(1, 1, 1, "R6/R10");
    step(0, 0, 1, "R11");
    step(0, 0, 0, "R4/R11");
    for (int i = 0; i < SLP + 3; i++) step(1, 0, 1, "R7/R11");
    step(1, 0, 0, "R9");

    @(posedge clk);
    #6;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule